// File: doc/BRIEF.md
# Receive Serial Address Filter

This block sits on a receive path between a character decoder and a receive FIFO. Each cycle it may take one decoded character, made of a 3-bit format code and an 8-bit payload. A character with format `111` is an address marker. The block compares the marker against a locally programmed address. The result sets an accept switch, and that switch decides whether the data characters that follow are written onward or dropped. A remote transmitter can therefore steer traffic to one receiver or to a group of receivers, using only in-band markers.

The local address register has two modes:
- **Unicast:** a marker matches only when it equals the register exactly.
- **Multicast:** the register is a group field, and a marker matches when it shares at least one set bit with that field.

A multicast field of all ones accepts all traffic, with no marker needed.

The block also pulls interrupt commands out of the stream and drives an active-low interrupt line from them. Whether those commands also reach the FIFO depends on a discard-policy input. A host port reads and writes the address register and its mode. The host port works only while the port is addressed and the receive path is held in reset.

Top module: `rx_addr_filter`

## Requirements
- R1: After `rst_n` is released, the accept switch is off, the register reads back as address 0x00 in unicast mode (`host_rmode` = 0), `irq_n` is 1 and `fifo_wr` is 0.
- R2: A valid character with format `111` is never written to the FIFO.
- R3: In unicast mode, a marker equal to the register turns the switch on. Any other marker turns it off.
- R4: In multicast mode, a marker turns the switch on when the bitwise AND of the marker and the register is non-zero. Otherwise the marker turns the switch off.
- R5: In multicast mode with a register value of all ones, every data character is forwarded, with or without a prior marker and whatever markers arrive.
- R6: A valid non-marker character that arrives while the block accepts is presented on `fifo_wr`/`fifo_fmt`/`fifo_data` one cycle later, unchanged. While the block does not accept, `fifo_wr` stays 0.
- R7: A valid character with format `001` and payload `IRQ_ON_CODE` (default 0x7C) drives `irq_n` to 0 one cycle later. Format `001` with payload `IRQ_OFF_CODE` (default 0x7D) drives `irq_n` to 1. Both happen regardless of the switch.
- R8: When `cmd_policy` is 0, interrupt commands are forwarded like data. When `cmd_policy` is non-zero, they are dropped. Other format-`001` characters are always forwarded like data.
- R9: The register and its mode are written (from `host_wdata` and `host_mcast`) only in a cycle where `host_sel_n` = 0, `rx_rst_n` = 0 and `host_rd_wn` = 0. A cycle that lacks any one of these leaves the register unchanged.
- R10: A cycle where `host_sel_n` = 0, `rx_rst_n` = 0 and `host_rd_wn` = 1 loads `host_rdata`/`host_rmode` with the register contents one cycle later. In all other cycles they hold their value.
- R11: While `rx_rst_n` = 0, incoming characters are ignored and the switch is forced off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | A decoded character is present |
| chr_fmt | input | 3 | Format code of the character |
| chr_data | input | DATA_W | Payload of the character |
| cmd_policy | input | POL_W | Discard policy; 0 forwards interrupt commands |
| host_sel_n | input | 1 | Host port addressed, active low |
| rx_rst_n | input | 1 | Receive-path reset, active low; enables host access |
| host_rd_wn | input | 1 | 1 = read, 0 = write |
| host_mcast | input | 1 | Mode written with the register: 1 = multicast |
| host_wdata | input | DATA_W | Register write value |
| host_rdata | output | DATA_W | Register read value |
| host_rmode | output | 1 | Mode read value |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_fmt | output | 3 | Format code of the forwarded character |
| fifo_data | output | DATA_W | Payload of the forwarded character |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
A wrong switch state is visible on the first data character after a marker. That character either appears on `fifo_wr` one cycle later when it should not, or is missing when it should be present. The bench therefore follows every one of the 256 marker values with a data character, in each register setting. A corrupted register value or mode shows up the same way, and it also shows up directly on the next host read. A stale interrupt state is visible on `irq_n` in the cycle after the command.

// File: rtl/rxaf_pkg.sv
`timescale 1ns/1ps
package rxaf_pkg;

  localparam int unsigned FMT_W = 3;

  typedef logic [FMT_W-1:0] fmt_t;

  localparam fmt_t FMT_MARK = 3'b111;
  localparam fmt_t FMT_CMD  = 3'b001;

  typedef enum logic [2:0] {
    CL_DATA    = 3'd0,
    CL_MARK    = 3'd1,
    CL_CMD     = 3'd2,
    CL_IRQ_ON  = 3'd3,
    CL_IRQ_OFF = 3'd4
  } chr_class_t;

endpackage

// File: rtl/rxaf_classify.sv
`timescale 1ns/1ps
module rxaf_classify
  import rxaf_pkg::*;
#(
  parameter int unsigned          DATA_W       = 8,
  parameter logic [DATA_W-1:0]    IRQ_ON_CODE  = 8'h7C,
  parameter logic [DATA_W-1:0]    IRQ_OFF_CODE = 8'h7D
) (
  input  fmt_t              fmt,
  input  logic [DATA_W-1:0] data,
  output chr_class_t        cls
);

  always_comb begin
    cls = CL_DATA;
    if (fmt == FMT_MARK) begin
      cls = CL_MARK;
    end else if (fmt == FMT_CMD) begin
      if (data == IRQ_ON_CODE) begin
        cls = CL_IRQ_ON;
      end else if (data == IRQ_OFF_CODE) begin
        cls = CL_IRQ_OFF;
      end else begin
        cls = CL_CMD;
      end
    end
  end

endmodule

// File: rtl/rxaf_addr_cmp.sv
`timescale 1ns/1ps
module rxaf_addr_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] reg_addr,
  input  logic              reg_mcast,
  input  logic [DATA_W-1:0] rx_addr,
  output logic              hit,
  output logic              bypass
);

  logic [DATA_W-1:0] eq_bit;
  logic [DATA_W-1:0] grp_bit;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign eq_bit[b]  = ~(reg_addr[b] ^ rx_addr[b]);
    assign grp_bit[b] = reg_addr[b] & rx_addr[b];
  end

  always_comb begin
    if (reg_mcast) begin
      hit = |grp_bit;
    end else begin
      hit = &eq_bit;
    end
    bypass = reg_mcast & (&reg_addr);
  end

endmodule

// File: rtl/rxaf_addr_reg.sv
`timescale 1ns/1ps
module rxaf_addr_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel_n,
  input  logic              rx_rst_n,
  input  logic              host_rd_wn,
  input  logic              host_mcast,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rmode,
  output logic [DATA_W-1:0] reg_addr,
  output logic              reg_mcast
);

  logic              access;
  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic              mc_q, mc_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              rmod_q, rmod_d;

  always_comb begin
    access = ~host_sel_n & ~rx_rst_n;
    wr_en  = access & ~host_rd_wn;
    rd_en  = access & host_rd_wn;
    addr_d = addr_q;
    mc_d   = mc_q;
    rdat_d = rdat_q;
    rmod_d = rmod_q;
    if (wr_en) begin
      addr_d = host_wdata;
      mc_d   = host_mcast;
    end
    if (rd_en) begin
      rdat_d = addr_q;
      rmod_d = mc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mc_q   <= 1'b0;
      rdat_q <= '0;
      rmod_q <= 1'b0;
    end else begin
      if (wr_en) begin
        addr_q <= addr_d;
        mc_q   <= mc_d;
      end
      if (rd_en) begin
        rdat_q <= rdat_d;
        rmod_q <= rmod_d;
      end
    end
  end

  assign reg_addr   = addr_q;
  assign reg_mcast  = mc_q;
  assign host_rdata = rdat_q;
  assign host_rmode = rmod_q;

endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int unsigned       DATA_W       = 8,
  parameter int unsigned       POL_W        = 2,
  parameter logic [DATA_W-1:0] IRQ_ON_CODE  = 8'h7C,
  parameter logic [DATA_W-1:0] IRQ_OFF_CODE = 8'h7D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_valid,
  input  logic [2:0]        chr_fmt,
  input  logic [DATA_W-1:0] chr_data,
  input  logic [POL_W-1:0]  cmd_policy,
  input  logic              host_sel_n,
  input  logic              rx_rst_n,
  input  logic              host_rd_wn,
  input  logic              host_mcast,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rmode,
  output logic              fifo_wr,
  output logic [2:0]        fifo_fmt,
  output logic [DATA_W-1:0] fifo_data,
  output logic              irq_n
);

  localparam logic [POL_W-1:0] POL_KEEP = '0;

  logic [DATA_W-1:0] reg_addr;
  logic              reg_mcast;
  logic              hit;
  logic              bypass;
  chr_class_t        cls;

  logic              active;
  logic              accept;
  logic              fwd;
  logic              sw_q, sw_d;
  logic              irq_q, irq_d;
  logic              wr_q;
  fmt_t              fmt_q;
  logic [DATA_W-1:0] dat_q;

  rxaf_addr_reg #(.DATA_W(DATA_W)) i_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel_n (host_sel_n),
    .rx_rst_n   (rx_rst_n),
    .host_rd_wn (host_rd_wn),
    .host_mcast (host_mcast),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_rmode (host_rmode),
    .reg_addr   (reg_addr),
    .reg_mcast  (reg_mcast)
  );

  rxaf_addr_cmp #(.DATA_W(DATA_W)) i_cmp (
    .reg_addr  (reg_addr),
    .reg_mcast (reg_mcast),
    .rx_addr   (chr_data),
    .hit       (hit),
    .bypass    (bypass)
  );

  rxaf_classify #(
    .DATA_W       (DATA_W),
    .IRQ_ON_CODE  (IRQ_ON_CODE),
    .IRQ_OFF_CODE (IRQ_OFF_CODE)
  ) i_cls (
    .fmt  (chr_fmt),
    .data (chr_data),
    .cls  (cls)
  );

  // next state of switch, interrupt and forward decision
  always_comb begin
    active = chr_valid & rx_rst_n;
    accept = sw_q | bypass;
    sw_d   = sw_q;
    irq_d  = irq_q;
    fwd    = 1'b0;
    if (!rx_rst_n) begin
      sw_d = 1'b0;
    end else if (active) begin
      unique case (cls)
        CL_MARK:    sw_d = hit;
        CL_DATA,
        CL_CMD:     fwd  = accept;
        CL_IRQ_ON: begin
          irq_d = 1'b0;
          fwd   = accept & (cmd_policy == POL_KEEP);
        end
        CL_IRQ_OFF: begin
          irq_d = 1'b1;
          fwd   = accept & (cmd_policy == POL_KEEP);
        end
        default:    fwd  = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      irq_q <= 1'b1;
      wr_q  <= 1'b0;
      fmt_q <= '0;
      dat_q <= '0;
    end else begin
      sw_q  <= sw_d;
      irq_q <= irq_d;
      wr_q  <= fwd;
      if (fwd) begin
        fmt_q <= chr_fmt;
        dat_q <= chr_data;
      end
    end
  end

  assign fifo_wr   = wr_q;
  assign fifo_fmt  = fmt_q;
  assign fifo_data = dat_q;
  assign irq_n     = irq_q;

endmodule

// File: rtl/rxaf_checker.sv
`timescale 1ns/1ps
module rxaf_checker #(
  parameter int unsigned       DATA_W       = 8,
  parameter int unsigned       POL_W        = 2,
  parameter logic [DATA_W-1:0] IRQ_ON_CODE  = 8'h7C,
  parameter logic [DATA_W-1:0] IRQ_OFF_CODE = 8'h7D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chr_valid,
  input logic [2:0]        chr_fmt,
  input logic [DATA_W-1:0] chr_data,
  input logic [POL_W-1:0]  cmd_policy,
  input logic              host_sel_n,
  input logic              rx_rst_n,
  input logic              host_rd_wn,
  input logic [DATA_W-1:0] host_rdata,
  input logic              fifo_wr,
  input logic [DATA_W-1:0] fifo_data,
  input logic              irq_n
);

  logic is_irq_cmd;
  assign is_irq_cmd = chr_valid && rx_rst_n && chr_fmt == 3'b001 &&
                      (chr_data == IRQ_ON_CODE || chr_data == IRQ_OFF_CODE);

  assert_no_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chr_valid && chr_fmt == 3'b111) |-> !fifo_wr);

  assert_rst_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rx_rst_n) |-> !fifo_wr);

  assert_fwd_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_data == $past(chr_data) && $past(chr_valid)));

  assert_irq_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chr_valid && rx_rst_n && chr_fmt == 3'b001 && chr_data == IRQ_ON_CODE)
    |-> !irq_n);

  assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chr_valid && rx_rst_n && chr_fmt == 3'b001 && chr_data == IRQ_OFF_CODE)
    |-> irq_n);

  assert_policy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_irq_cmd && cmd_policy != '0) |-> !fifo_wr);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(!host_sel_n && !rx_rst_n && host_rd_wn)) |-> $stable(host_rdata));

endmodule

bind rx_addr_filter rxaf_checker #(
  .DATA_W       (DATA_W),
  .POL_W        (POL_W),
  .IRQ_ON_CODE  (IRQ_ON_CODE),
  .IRQ_OFF_CODE (IRQ_OFF_CODE)
) u_rxaf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .chr_valid  (chr_valid),
  .chr_fmt    (chr_fmt),
  .chr_data   (chr_data),
  .cmd_policy (cmd_policy),
  .host_sel_n (host_sel_n),
  .rx_rst_n   (rx_rst_n),
  .host_rd_wn (host_rd_wn),
  .host_rdata (host_rdata),
  .fifo_wr    (fifo_wr),
  .fifo_data  (fifo_data),
  .irq_n      (irq_n)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chr_valid = 1'b0;
  logic [2:0] chr_fmt = 3'b000;
  logic [7:0] chr_data = 8'h00;
  logic [1:0] cmd_policy = 2'd0;
  logic       host_sel_n = 1'b1;
  logic       rx_rst_n = 1'b1;
  logic       host_rd_wn = 1'b1;
  logic       host_mcast = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_rmode;
  logic       fifo_wr;
  logic [2:0] fifo_fmt;
  logic [7:0] fifo_data;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_fmt(chr_fmt),
    .chr_data(chr_data), .cmd_policy(cmd_policy), .host_sel_n(host_sel_n),
    .rx_rst_n(rx_rst_n), .host_rd_wn(host_rd_wn), .host_mcast(host_mcast),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rmode(host_rmode),
    .fifo_wr(fifo_wr), .fifo_fmt(fifo_fmt), .fifo_data(fifo_data), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock; outputs sampled 5 ns after the edge
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic send(input logic [2:0] f, input logic [7:0] d);
    chr_valid = 1'b1; chr_fmt = f; chr_data = d;
    tick();
    chr_valid = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] v, input logic mc);
    rx_rst_n = 1'b0; host_sel_n = 1'b0; host_rd_wn = 1'b0;
    host_wdata = v; host_mcast = mc;
    tick();
    host_sel_n = 1'b1; host_rd_wn = 1'b1; rx_rst_n = 1'b1;
  endtask

  task automatic host_rd(input string req, input logic [7:0] v, input logic mc);
    rx_rst_n = 1'b0; host_sel_n = 1'b0; host_rd_wn = 1'b1;
    tick();
    host_sel_n = 1'b1; rx_rst_n = 1'b1;
    chk(req, host_rdata, v);
    chk(req, host_rmode, mc);
  endtask

  // marker m then data; expect forwarding iff exp
  task automatic probe(input string req, input logic [7:0] m, input bit exp);
    logic [7:0] d;
    d = m ^ 8'h3C;
    send(3'b111, m);
    chk("R2 marker not forwarded", fifo_wr, 0);
    send(3'b000, d);
    chk(req, fifo_wr, exp);
    if (exp) chk("R6 data unchanged", fifo_data, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ua [3] = '{8'h00, 8'h5A, 8'hFF};
    logic [7:0] mf [4] = '{8'h01, 8'h81, 8'h3C, 8'h00};
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    chk("R1 fifo_wr", fifo_wr, 0);
    send(3'b000, 8'h42);
    chk("R1 switch off at reset", fifo_wr, 0);
    host_rd("R1 register reset", 8'h00, 1'b0);

    // R3 unicast sweep
    foreach (ua[i]) begin
      host_wr(ua[i], 1'b0);
      host_rd("R9 write unicast", ua[i], 1'b0);
      for (int m = 0; m < 256; m++)
        probe("R3 unicast match", m[7:0], m[7:0] == ua[i]);
    end

    // R4 multicast sweep
    foreach (mf[i]) begin
      host_wr(mf[i], 1'b1);
      host_rd("R9 write multicast", mf[i], 1'b1);
      for (int m = 0; m < 256; m++)
        probe("R4 multicast match", m[7:0], (m[7:0] & mf[i]) != 8'h00);
    end

    // R5 all-ones multicast
    host_wr(8'hFF, 1'b1);
    send(3'b000, 8'hA5);
    chk("R5 no marker needed", fifo_wr, 1);
    for (int m = 0; m < 256; m += 17) begin
      send(3'b111, 8'h00);
      send(3'b010, m[7:0]);
      chk("R5 accept after non-matching marker", fifo_wr, 1);
      chk("R6 fmt unchanged", fifo_fmt, 3'b010);
    end

    // R7 / R8 interrupt commands
    host_wr(8'h21, 1'b0);
    send(3'b111, 8'h20);                       // switch off
    send(3'b001, 8'h7C);
    chk("R7 irq on with switch off", irq_n, 0);
    chk("R8 not forwarded while off", fifo_wr, 0);
    send(3'b001, 8'h7D);
    chk("R7 irq off", irq_n, 1);
    send(3'b111, 8'h21);                       // switch on
    cmd_policy = 2'd0;
    send(3'b001, 8'h7C);
    chk("R8 policy 0 forwards", fifo_wr, 1);
    chk("R8 policy 0 data", fifo_data, 8'h7C);
    chk("R7 irq on", irq_n, 0);
    for (int p = 1; p < 4; p++) begin
      cmd_policy = p[1:0];
      send(3'b001, 8'h7D);
      chk("R8 nonzero policy drops", fifo_wr, 0);
      chk("R7 irq off under policy", irq_n, 1);
      send(3'b001, 8'h11);
      chk("R8 other command forwarded", fifo_wr, 1);
      send(3'b001, 8'h7C);
      chk("R8 nonzero policy drops on", fifo_wr, 0);
    end
    cmd_policy = 2'd0;
    send(3'b001, 8'h7D);

    // R9 ignored writes
    rx_rst_n = 1'b0; host_sel_n = 1'b1; host_rd_wn = 1'b0;
    host_wdata = 8'h99; host_mcast = 1'b1;
    tick();
    rx_rst_n = 1'b1; host_sel_n = 1'b0;
    tick();
    host_sel_n = 1'b1; host_rd_wn = 1'b1;
    host_rd("R9 write ignored", 8'h21, 1'b0);

    // R10 read data holds without read access
    host_wr(8'h44, 1'b0);
    chk("R10 rdata held after write", host_rdata, 8'h21);
    tick();
    chk("R10 rdata held idle", host_rdata, 8'h21);
    host_rd("R10 read", 8'h44, 1'b0);

    // R11 receive reset
    send(3'b111, 8'h44);
    send(3'b000, 8'h01);
    chk("R11 switch on before reset", fifo_wr, 1);
    rx_rst_n = 1'b0;
    send(3'b000, 8'h02);
    chk("R11 ignored during rx reset", fifo_wr, 0);
    rx_rst_n = 1'b1;
    send(3'b000, 8'h03);
    chk("R11 switch off after rx reset", fifo_wr, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule